// File: doc/BRIEF.md
# Transmit Delay and Line-Hold Controller

This block sits between a source of transmit characters and a serial shifter. It reads commands that are carried in band within the byte stream. When command decoding is enabled, an escape byte introduces a command. A command can force the line low (break), release that break, or stall the stream for a timed number of ticks. While the stall lasts, the line is held at a fixed level. When decoding is disabled, every byte goes straight through to the shifter.

The stream input uses a valid/ready handshake. The shifter's ready input also serves as its idle indication. On the shifter side the block presents a character with a valid strobe. It also drives a line-override enable with a level, so that the shifter's line driver can be overridden, and a busy flag that is high while the delay timer runs. Baud generation and serialisation are outside this block.

Top module: `txHoldTop`

## Requirements
- R1: While `cmdEn` is low, every byte value, including 0x00, passes through: `outValid` equals `inValid`, `outData` equals `inData`, `inReady` equals `shReady`, and `lineForce` is 0.
- R2: While `cmdEn` is high, byte 0x00 is an escape and is consumed without reaching the shifter. The two-byte sequence 0x00 0x00 delivers a single data byte 0x00.
- R3: The sequence 0x00 0x82 P loads the period P into the delay timer. The timer then decrements by one on each clock edge that sees `tick` high. `busy` is high exactly while the timer is non-zero, so the hold lasts exactly P ticks.
- R4: While `busy` is high, `inReady` and `outValid` are both 0, whatever byte is offered.
- R5: The period byte is accepted only while `shReady` is high. A delay never starts while the shifter is not idle.
- R6: During a delay with no break active, `lineForce`=1 and `lineLevel`=1. In the cycle the timer reaches zero, `busy` and `lineForce` both fall.
- R7: The sequence 0x00 0x81 starts a break, which holds `lineForce`=1 and `lineLevel`=0 until 0x00 0x83 ends it. During the break, data bytes stall, with `inReady` and `outValid` at 0, while command bytes are still consumed.
- R8: A delay started during a break holds the line at level 0.
- R9: A period of 0 produces no hold. The next data byte is presented at once.
- R10: After an escape, any command byte other than 0x00, 0x81, 0x82 or 0x83 is consumed and discarded. The stream then carries on as data.
- R11: Lowering `cmdEn` cancels at once any break, running delay or pending escape. `busy` and `lineForce` are 0 in that same cycle, and the cancelled state does not return when `cmdEn` rises again.
- R12: After reset, `busy`=0, `lineForce`=0 and `lineLevel`=1, and no escape is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdEn | input | 1 | Enables in-band command decoding |
| tick | input | 1 | Delay timer decrement strobe |
| inData | input | DATA_W | Stream byte |
| inValid | input | 1 | Stream byte valid |
| inReady | output | 1 | Stream byte accepted |
| shReady | input | 1 | Shifter ready / idle |
| outData | output | DATA_W | Character to shifter |
| outValid | output | 1 | Character valid to shifter |
| lineForce | output | 1 | Line override enable |
| lineLevel | output | 1 | Forced line level |
| busy | output | 1 | Delay timer running |

## Verification
The bench builds the block with its default 8-bit byte width and the default command codes. At that width the entire byte space can be covered. Every value is swept in pass-through mode and every command code after an escape, and every period from 0 to 255 runs to completion with a tick on every cycle. A second sweep of periods ticks only every third cycle, which confirms that the hold length follows ticks rather than clock cycles.

// File: rtl/txHoldPkg.sv
package txHoldPkg;
  typedef enum logic [1:0] {
    ST_TEXT = 2'd0,
    ST_ESC  = 2'd1,
    ST_PER  = 2'd2
  } decSt_t;

  typedef struct packed {
    logic loadTimer;
    logic setBrk;
    logic clrBrk;
    logic clrAll;
  } ctlStrb_t;
endpackage

// File: rtl/txHoldCtrl.sv
module txHoldCtrl
  import txHoldPkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] ESC_CODE = 8'h00,
  parameter logic [DATA_W-1:0] BRK_ON_CODE = 8'h81,
  parameter logic [DATA_W-1:0] DLY_CODE = 8'h82,
  parameter logic [DATA_W-1:0] BRK_OFF_CODE = 8'h83
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdEn,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  logic              shReady,
  input  logic              timerBusy,
  input  logic              brkOn,
  output logic              inReady,
  output logic              outValid,
  output ctlStrb_t          strb
);
  decSt_t st, stNxt;
  logic dataSel, perSel, dataGo, blocked, brkGate, acc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_TEXT;
    else       st <= stNxt;
  end

  always_comb begin
    blocked = timerBusy & cmdEn;
    brkGate = brkOn & cmdEn;
    dataGo  = ~blocked & ~brkGate;
    dataSel = 1'b0;
    perSel  = 1'b0;
    stNxt   = st;
    strb    = '0;
    if (!cmdEn) begin
      dataSel     = 1'b1;
      strb.clrAll = 1'b1;
      stNxt       = ST_TEXT;
    end else begin
      unique case (st)
        ST_TEXT: dataSel = (inData != ESC_CODE);
        ST_ESC:  dataSel = (inData == ESC_CODE);
        ST_PER:  perSel  = 1'b1;
        default: dataSel = 1'b0;
      endcase
    end
    outValid = inValid & dataSel & dataGo;
    if (dataSel)     inReady = shReady & dataGo;
    else if (perSel) inReady = shReady & ~blocked;
    else             inReady = ~blocked;
    acc = inValid & inReady;
    if (cmdEn && acc) begin
      unique case (st)
        ST_TEXT: if (inData == ESC_CODE) stNxt = ST_ESC;
        ST_ESC: begin
          stNxt = ST_TEXT;
          if (inData == DLY_CODE)          stNxt = ST_PER;
          else if (inData == BRK_ON_CODE)  strb.setBrk = 1'b1;
          else if (inData == BRK_OFF_CODE) strb.clrBrk = 1'b1;
        end
        ST_PER: begin
          stNxt = ST_TEXT;
          strb.loadTimer = 1'b1;
        end
        default: stNxt = ST_TEXT;
      endcase
    end
  end
endmodule

// File: rtl/txHoldPath.sv
module txHoldPath
  import txHoldPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdEn,
  input  logic              tick,
  input  logic [DATA_W-1:0] inData,
  input  ctlStrb_t          strb,
  output logic [DATA_W-1:0] outData,
  output logic [DATA_W-1:0] timerCnt,
  output logic              timerBusy,
  output logic              brkOn,
  output logic              lineForce,
  output logic              lineLevel,
  output logic              busy
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerCnt <= '0;
      brkOn    <= 1'b0;
    end else if (strb.clrAll) begin
      timerCnt <= '0;
      brkOn    <= 1'b0;
    end else begin
      if (strb.loadTimer)           timerCnt <= inData;
      else if (tick && timerBusy)   timerCnt <= timerCnt - ONE;
      if (strb.setBrk)      brkOn <= 1'b1;
      else if (strb.clrBrk) brkOn <= 1'b0;
    end
  end

  always_comb begin
    timerBusy = (timerCnt != '0);
    busy      = cmdEn & timerBusy;
    lineForce = cmdEn & (brkOn | timerBusy);
    lineLevel = ~(cmdEn & brkOn);
    outData   = inData;
  end
endmodule

// File: rtl/txHoldTop.sv
module txHoldTop
  import txHoldPkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] ESC_CODE = 8'h00,
  parameter logic [DATA_W-1:0] BRK_ON_CODE = 8'h81,
  parameter logic [DATA_W-1:0] DLY_CODE = 8'h82,
  parameter logic [DATA_W-1:0] BRK_OFF_CODE = 8'h83
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdEn,
  input  logic              tick,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  input  logic              shReady,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              lineForce,
  output logic              lineLevel,
  output logic              busy
);
  ctlStrb_t strb;
  logic timerBusy, brkOn;
  logic [DATA_W-1:0] timerCnt;

  txHoldCtrl #(
    .DATA_W(DATA_W), .ESC_CODE(ESC_CODE), .BRK_ON_CODE(BRK_ON_CODE),
    .DLY_CODE(DLY_CODE), .BRK_OFF_CODE(BRK_OFF_CODE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdEn(cmdEn), .inData(inData),
    .inValid(inValid), .shReady(shReady), .timerBusy(timerBusy),
    .brkOn(brkOn), .inReady(inReady), .outValid(outValid), .strb(strb)
  );

  txHoldPath #(.DATA_W(DATA_W)) u_path (
    .clk(clk), .rstN(rstN), .cmdEn(cmdEn), .tick(tick), .inData(inData),
    .strb(strb), .outData(outData), .timerCnt(timerCnt),
    .timerBusy(timerBusy), .brkOn(brkOn), .lineForce(lineForce),
    .lineLevel(lineLevel), .busy(busy)
  );
endmodule

// File: rtl/txHoldChk.sv
module txHoldChk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdEn,
  input logic              tick,
  input logic              inValid,
  input logic              inReady,
  input logic              shReady,
  input logic              outValid,
  input logic              lineForce,
  input logic              lineLevel,
  input logic              busy,
  input logic [DATA_W-1:0] timerCnt
);
  assert_bypass_R1: assert property (@(posedge clk) disable iff (!rstN)
    !cmdEn |-> (outValid == inValid) && (inReady == shReady) && !lineForce);

  assert_tick_dec_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && tick && cmdEn) |=> timerCnt == $past(timerCnt) - DATA_W'(1));

  assert_hold_still_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !tick && cmdEn) |=> $stable(timerCnt));

  assert_stall_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !inReady && !outValid);

  assert_force_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> lineForce);

  assert_idle_high_R12: assert property (@(posedge clk) disable iff (!rstN)
    !lineForce |-> lineLevel);
endmodule

bind txHoldTop txHoldChk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdEn(cmdEn), .tick(tick), .inValid(inValid),
  .inReady(inReady), .shReady(shReady), .outValid(outValid),
  .lineForce(lineForce), .lineLevel(lineLevel), .busy(busy),
  .timerCnt(timerCnt)
);

// File: tb/sim_txHoldTop.sv
module sim_txHoldTop;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdEn = 1'b0;
  logic tick = 1'b0;
  logic [7:0] inData = 8'h00;
  logic inValid = 1'b0;
  logic inReady;
  logic shReady = 1'b1;
  logic [7:0] outData;
  logic outValid, lineForce, lineLevel, busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic obsValid;
  logic [7:0] obsData;

  always #4 clk = ~clk;

  txHoldTop u0 (
    .clk(clk), .rstN(rstN), .cmdEn(cmdEn), .tick(tick), .inData(inData),
    .inValid(inValid), .inReady(inReady), .shReady(shReady),
    .outData(outData), .outValid(outValid), .lineForce(lineForce),
    .lineLevel(lineLevel), .busy(busy)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    inData = b; inValid = 1'b1; #1;
    while (!inReady) begin @(negedge clk); #1; end
    obsValid = outValid; obsData = outData;
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  task automatic runDelay(input int p, input logic brk, input int tickMod, input string tag);
    int ticks = 0;
    int guard = 0;
    int bad = 0;
    push(8'h00); push(8'h82); push(p[7:0]);
    inData = 8'h55; inValid = 1'b1;
    forever begin
      @(negedge clk); #1;
      if (!busy) break;
      if (!lineForce || lineLevel != !brk || inReady || outValid) bad++;
      tick = ((guard % tickMod) == 0);
      if (tick) ticks++;
      guard++;
      if (guard > 3000) break;
    end
    tick = 1'b0;
    chk(ticks == p, {tag, " R3 hold length in ticks"}, ticks, p);
    chk(bad == 0, {tag, " R4 R6 R8 hold outputs"}, bad, 0);
    chk(lineForce == brk, {tag, " R6 force released with timer"}, lineForce, brk);
    if (!brk) chk(outValid == 1'b1, {tag, " R9 data resumes"}, outValid, 1);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(busy == 0 && lineForce == 0 && lineLevel == 1, "R12 reset outputs",
        {busy, lineForce, lineLevel}, 3'b001);
    @(negedge clk); rstN = 1'b1;

    // R1 sweep of every byte with decoding off
    begin
      int bad = 0;
      for (int b = 0; b < 256; b++) begin
        @(negedge clk);
        inData = b[7:0]; inValid = 1'b1; shReady = b[0]; #1;
        if (outValid !== 1'b1 || outData !== b[7:0] || inReady !== shReady || lineForce !== 1'b0)
          bad++;
      end
      inValid = 1'b0; shReady = 1'b1;
      chk(bad == 0, "R1 pass-through sweep", bad, 0);
    end

    cmdEn = 1'b1;
    // R12: no escape pending after reset -> 0x41 is data
    push(8'h41);
    chk(obsValid && obsData == 8'h41, "R12 first byte is data", obsData, 8'h41);

    // R2 literal escape
    push(8'h00);
    chk(obsValid == 0, "R2 escape consumed", obsValid, 0);
    push(8'h00);
    chk(obsValid && obsData == 8'h00, "R2 literal zero", {obsValid, obsData}, 9'h100);

    // R10 sweep of unknown commands
    begin
      int bad = 0;
      for (int c = 1; c < 256; c++) begin
        if (c == 8'h81 || c == 8'h82 || c == 8'h83) continue;
        push(8'h00);
        if (obsValid) bad++;
        push(c[7:0]);
        if (obsValid) bad++;
        push(8'h5A);
        if (!obsValid || obsData != 8'h5A || lineForce || busy) bad++;
      end
      chk(bad == 0, "R10 unknown commands discarded", bad, 0);
    end

    // R3 R4 R6 R9: every period with tick each cycle
    for (int p = 0; p < 256; p++) runDelay(p, 1'b0, 1, "sweep1");
    // R3: tick every third cycle
    for (int p = 0; p < 40; p++) runDelay(p, 1'b0, 3, "sweep3");

    // R5 period byte waits for idle shifter
    shReady = 1'b0;
    push(8'h00); push(8'h82);
    @(negedge clk); inData = 8'h07; inValid = 1'b1; #1;
    repeat (3) begin
      chk(inReady == 0 && busy == 0, "R5 period held while shifter busy", {inReady, busy}, 0);
      @(negedge clk); #1;
    end
    shReady = 1'b1; #1;
    chk(inReady == 1, "R5 period accepted when idle", inReady, 1);
    @(posedge clk); #1; inValid = 1'b0; tick = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    chk(busy == 1, "R3 one tick left", busy, 1);
    @(posedge clk); #1;
    chk(busy == 0 && lineForce == 0, "R6 release on zero", {busy, lineForce}, 0);
    tick = 1'b0;

    // R7 break
    push(8'h00); push(8'h81);
    @(negedge clk); #1;
    chk(lineForce == 1 && lineLevel == 0, "R7 break forces low", {lineForce, lineLevel}, 2);
    inData = 8'h33; inValid = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      chk(inReady == 0 && outValid == 0, "R7 data stalls in break", {inReady, outValid}, 0);
    end
    inValid = 1'b0;
    // R8 delays during break
    runDelay(5, 1'b1, 1, "brk");
    runDelay(12, 1'b1, 2, "brk");
    push(8'h00); push(8'h83);
    @(negedge clk); inData = 8'h33; inValid = 1'b1; #1;
    chk(lineForce == 0 && lineLevel == 1 && outValid == 1, "R7 break ended",
        {lineForce, lineLevel, outValid}, 3'b011);
    inValid = 1'b0;

    // R11 cancel break and running delay
    push(8'h00); push(8'h81);
    push(8'h00); push(8'h82); push(8'd50);
    @(negedge clk); cmdEn = 1'b0; #1;
    chk(busy == 0 && lineForce == 0, "R11 cancel same cycle", {busy, lineForce}, 0);
    @(negedge clk); cmdEn = 1'b1; #1;
    chk(busy == 0 && lineForce == 0 && lineLevel == 1, "R11 stays cancelled",
        {busy, lineForce, lineLevel}, 3'b001);
    // R11 pending escape cleared
    push(8'h00);
    @(negedge clk); cmdEn = 1'b0;
    @(negedge clk); cmdEn = 1'b1;
    push(8'h82);
    chk(obsValid && obsData == 8'h82, "R11 escape dropped", obsData, 8'h82);
    chk(busy == 0, "R11 no delay started", busy, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule